// File: doc/BRIEF.md
# Three-Wire Serial Register Loader with Staged Modulus

This block receives 24-bit words over a three-wire serial link (a serial clock, a data line and a latch strobe) and steers each finished word into one of four destination registers. The two lowest bits of the word name the destination. The other bits carry the payload. The serial pins come from off-chip and are not related to the system clock. The block samples them on that faster clock through synchronizers and acts on the rising edges it detects.

The destinations hold the settings of a fractional-N divider: an integer part and a fraction, a reference divider with a modulus, a control word and a noise/spur word. The modulus is double buffered. A word that carries a new modulus only stages it. The value reaches the modulus output at the next integer/fraction write, so the fraction and the modulus it is measured against change in the same cycle. Every write also raises a one-cycle strobe on the line for its destination.

Top module: `serial_word_loader`

## Requirements
- R1: On each detected rising edge of `ser_clk` the block shifts in the synchronized `ser_dat` level, most significant bit first, into a 24-bit shift register.
- R2: On a detected rising edge of `ser_latch` the block uses the last 24 bits shifted in. Bits shifted before those have no effect.
- R3: Destination code 2'b00 (word bits 1:0) is the integer/fraction register: bits 13:2 go to `frac_val`, bits 22:14 go to `int_div` and bit 23 goes to `n_spare`.
- R4: Destination code 2'b01 is the reference register: bits 17:14 go to `ref_div`, bits 23:18 go to `r_spare`, and bits 13:2 are held as the staged modulus.
- R5: Destination code 2'b10 loads bits 23:2 into `ctl_word`. Code 2'b11 loads bits 23:2 into `nsp_word`.
- R6: A reference-register write leaves `mod_val` unchanged.
- R7: An integer/fraction write copies the modulus staged most recently to `mod_val`. If several reference writes came first, the last of them wins. An integer/fraction write with no reference write since the previous commit leaves `mod_val` at its committed value.
- R8: After reset every output is zero, except `mod_val` and the staged modulus, which are 2.
- R9: Each write pulses `upd[code]` high for exactly one cycle, in the same cycle the destination outputs take their new value. At most one bit of `upd` is high at a time.
- R10: A write changes no destination other than the one its code selects.
- R11: Serial clock edges without a latch edge change no output and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on ser_clk rising edges |
| ser_latch | input | 1 | Latch strobe; its rising edge commits the shifted word |
| ref_div | output | 4 | Reference divider value |
| int_div | output | 9 | Integer divider value |
| frac_val | output | 12 | Fractional numerator |
| mod_val | output | 12 | Active (committed) modulus |
| n_spare | output | 1 | Unassigned bit of the integer/fraction word |
| r_spare | output | 6 | Unassigned bits of the reference word |
| ctl_word | output | 22 | Payload of the control word |
| nsp_word | output | 22 | Payload of the noise/spur word |
| upd | output | 4 | One-cycle write strobes, indexed by destination code |

## Verification
The assertions assume the serial pins are slow compared with the system clock. Every high and low phase of `ser_clk` and `ser_latch` must last longer than the synchronizer depth plus one cycle. `ser_dat` must stay steady around each `ser_clk` rise, and `ser_latch` must not rise while a word is still being shifted in. Under these conditions each pin edge gives exactly one detected edge, and data and clock pass through synchronizers of the same depth. The bench keeps within these limits. It changes data four system cycles before each serial clock rise, holds every serial level for four cycles, and raises the latch only after the last bit has been shifted in.

// File: rtl/swl_pkg.sv
package swl_pkg;

   typedef enum logic [1:0] {
      DST_INT = 2'b00,
      DST_REF = 2'b01,
      DST_CTL = 2'b10,
      DST_NSP = 2'b11
   } dst_e;

   localparam int unsigned DST_COUNT = 4;
   localparam int unsigned CODE_W    = 2;

endpackage

// File: rtl/swl_sync_cell.sv
module swl_sync_cell #(
   parameter int unsigned STAGES   = 2,
   parameter bit          RISE_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("swl_sync_cell: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   if (RISE_OUT) begin : g_rise
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= chain_q[STAGES-1];
      end
      assign q = chain_q[STAGES-1] & ~prev_q;

      // R1/R2: a detected edge is never two cycles long
      p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
         q |=> !q);
   end else begin : g_level
      assign q = chain_q[STAGES-1];
   end

endmodule

// File: rtl/swl_shift_capture.sv
module swl_shift_capture #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] word
);

   if (WORD_W < 3) begin : g_bad_width
      $error("swl_shift_capture: WORD_W too small");
   end

   logic [WORD_W-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        sr_q <= '0;
      else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], din};
   end

   assign word = sr_q;

   // R11: without a serial clock edge the shift register holds
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word));

endmodule

// File: rtl/swl_reg_bank.sv
module swl_reg_bank
   import swl_pkg::*;
#(
   parameter int unsigned WORD_W    = 24,
   parameter int unsigned RDIV_W    = 4,
   parameter int unsigned INT_W     = 9,
   parameter int unsigned FRAC_W    = 12,
   parameter int unsigned MOD_RESET = 2,
   localparam int unsigned PAY_W    = WORD_W - CODE_W,
   localparam int unsigned NSP_W    = PAY_W - FRAC_W - INT_W,
   localparam int unsigned RSP_W    = PAY_W - FRAC_W - RDIV_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [WORD_W-1:0]    word,
   output logic [RDIV_W-1:0]    ref_div,
   output logic [INT_W-1:0]     int_div,
   output logic [FRAC_W-1:0]    frac_val,
   output logic [FRAC_W-1:0]    mod_val,
   output logic [NSP_W-1:0]     n_spare,
   output logic [RSP_W-1:0]     r_spare,
   output logic [PAY_W-1:0]     ctl_word,
   output logic [PAY_W-1:0]     nsp_word,
   output logic [DST_COUNT-1:0] upd
);

   if (FRAC_W + INT_W + 1 > PAY_W) begin : g_bad_n_layout
      $error("swl_reg_bank: integer and fraction fields do not fit");
   end
   if (FRAC_W + RDIV_W + 1 > PAY_W) begin : g_bad_r_layout
      $error("swl_reg_bank: modulus and reference fields do not fit");
   end
   if (MOD_RESET == 0 || MOD_RESET >= (1 << FRAC_W)) begin : g_bad_mod_reset
      $error("swl_reg_bank: MOD_RESET must be nonzero and fit the modulus");
   end

   localparam int unsigned F_LO  = CODE_W;
   localparam int unsigned F_HI  = F_LO + FRAC_W - 1;
   localparam int unsigned I_LO  = F_HI + 1;
   localparam int unsigned I_HI  = I_LO + INT_W - 1;
   localparam int unsigned R_LO  = F_HI + 1;
   localparam int unsigned R_HI  = R_LO + RDIV_W - 1;
   localparam logic [FRAC_W-1:0] MOD_INIT = FRAC_W'(MOD_RESET);

   dst_e                 sel;
   logic [RDIV_W-1:0]    ref_q;
   logic [INT_W-1:0]     int_q;
   logic [FRAC_W-1:0]    frac_q;
   logic [FRAC_W-1:0]    mod_stg_q;
   logic [FRAC_W-1:0]    mod_act_q;
   logic [NSP_W-1:0]     nsp_q;
   logic [RSP_W-1:0]     rsp_q;
   logic [PAY_W-1:0]     ctl_q;
   logic [PAY_W-1:0]     noise_q;
   logic [DST_COUNT-1:0] upd_q;

   assign sel = dst_e'(word[CODE_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q     <= '0;
         int_q     <= '0;
         frac_q    <= '0;
         nsp_q     <= '0;
         rsp_q     <= '0;
         ctl_q     <= '0;
         noise_q   <= '0;
         mod_stg_q <= MOD_INIT;
         mod_act_q <= MOD_INIT;
         upd_q     <= '0;
      end else begin
         upd_q <= '0;
         if (wr_en) begin
            upd_q[sel] <= 1'b1;
            unique case (sel)
               DST_INT: begin
                  frac_q    <= word[F_HI:F_LO];
                  int_q     <= word[I_HI:I_LO];
                  nsp_q     <= word[WORD_W-1:I_HI+1];
                  mod_act_q <= mod_stg_q;
               end
               DST_REF: begin
                  mod_stg_q <= word[F_HI:F_LO];
                  ref_q     <= word[R_HI:R_LO];
                  rsp_q     <= word[WORD_W-1:R_HI+1];
               end
               DST_CTL: ctl_q   <= word[WORD_W-1:CODE_W];
               DST_NSP: noise_q <= word[WORD_W-1:CODE_W];
               default: ;
            endcase
         end
      end
   end

   assign ref_div  = ref_q;
   assign int_div  = int_q;
   assign frac_val = frac_q;
   assign mod_val  = mod_act_q;
   assign n_spare  = nsp_q;
   assign r_spare  = rsp_q;
   assign ctl_word = ctl_q;
   assign nsp_word = noise_q;
   assign upd      = upd_q;

   // R9: every write gives exactly one strobe, no write gives none
   p_strobe_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> $countones(upd) == 1);
   p_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> upd == '0);
   // R6: the active modulus moves only on an integer/fraction write
   p_mod_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == DST_INT) |=> $stable(mod_val));
   // R7: the commit takes the value staged before the write
   p_mod_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == DST_INT) |=> mod_val == $past(mod_stg_q));
   // R10: reference and control outputs move only on their own writes
   p_ref_own_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == DST_REF) |=> $stable(ref_div));
   p_ctl_own_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == DST_CTL) |=> $stable(ctl_word));

endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
   import swl_pkg::*;
#(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned RDIV_W      = 4,
   parameter int unsigned INT_W       = 9,
   parameter int unsigned FRAC_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MOD_RESET   = 2,
   localparam int unsigned PAY_W      = WORD_W - CODE_W,
   localparam int unsigned NSP_W      = PAY_W - FRAC_W - INT_W,
   localparam int unsigned RSP_W      = PAY_W - FRAC_W - RDIV_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_dat,
   input  logic                 ser_latch,
   output logic [RDIV_W-1:0]    ref_div,
   output logic [INT_W-1:0]     int_div,
   output logic [FRAC_W-1:0]    frac_val,
   output logic [FRAC_W-1:0]    mod_val,
   output logic [NSP_W-1:0]     n_spare,
   output logic [RSP_W-1:0]     r_spare,
   output logic [PAY_W-1:0]     ctl_word,
   output logic [PAY_W-1:0]     nsp_word,
   output logic [DST_COUNT-1:0] upd
);

   logic              sclk_rise;
   logic              latch_rise;
   logic              dat_lvl;
   logic [WORD_W-1:0] sr_word;

   swl_sync_cell #(.STAGES(SYNC_STAGES), .RISE_OUT(1'b1)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_rise));

   swl_sync_cell #(.STAGES(SYNC_STAGES), .RISE_OUT(1'b1)) u_sync_latch (
      .clk(clk), .rst_n(rst_n), .d(ser_latch), .q(latch_rise));

   swl_sync_cell #(.STAGES(SYNC_STAGES), .RISE_OUT(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(ser_dat), .q(dat_lvl));

   swl_shift_capture #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .din(dat_lvl),
      .word(sr_word));

   swl_reg_bank #(
      .WORD_W(WORD_W), .RDIV_W(RDIV_W), .INT_W(INT_W),
      .FRAC_W(FRAC_W), .MOD_RESET(MOD_RESET)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(latch_rise), .word(sr_word),
      .ref_div(ref_div), .int_div(int_div), .frac_val(frac_val),
      .mod_val(mod_val), .n_spare(n_spare), .r_spare(r_spare),
      .ctl_word(ctl_word), .nsp_word(nsp_word), .upd(upd));

   // R9: strobes never overlap at the block edge
   p_upd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd));

endmodule

// File: tb/sim_serial_word_loader.sv
module sim_serial_word_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_latch = 1'b0;
   logic [3:0]  ref_div;
   logic [8:0]  int_div;
   logic [11:0] frac_val;
   logic [11:0] mod_val;
   logic [0:0]  n_spare;
   logic [5:0]  r_spare;
   logic [21:0] ctl_word;
   logic [21:0] nsp_word;
   logic [3:0]  upd;

   always #2 clk = ~clk;

   serial_word_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_latch(ser_latch), .ref_div(ref_div), .int_div(int_div),
      .frac_val(frac_val), .mod_val(mod_val), .n_spare(n_spare),
      .r_spare(r_spare), .ctl_word(ctl_word), .nsp_word(nsp_word),
      .upd(upd));

   int n_chk = 0;
   int n_fail = 0;

   logic [3:0]  e_ref;  logic [8:0]  e_int;  logic [11:0] e_frac;
   logic [11:0] e_mod;  logic [11:0] e_stg;  logic [0:0]  e_nsp1;
   logic [5:0]  e_rsp;  logic [21:0] e_ctl;  logic [21:0] e_noise;
   int e_cnt [4];
   int s_cnt [4];
   int s_wide = 0;
   int s_multi = 0;
   logic [3:0] upd_prev = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 4; i++) begin
            if (upd[i]) s_cnt[i]++;
            if (upd[i] && upd_prev[i]) s_wide++;
         end
         if ($countones(upd) > 1) s_multi++;
         upd_prev <= upd;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({"R3/R10 frac ", tag}, 32'(frac_val), 32'(e_frac));
      chk({"R3/R10 int ", tag}, 32'(int_div), 32'(e_int));
      chk({"R3/R10 n spare ", tag}, 32'(n_spare), 32'(e_nsp1));
      chk({"R4/R10 ref ", tag}, 32'(ref_div), 32'(e_ref));
      chk({"R4/R10 r spare ", tag}, 32'(r_spare), 32'(e_rsp));
      chk({"R6/R7 mod ", tag}, 32'(mod_val), 32'(e_mod));
      chk({"R5/R10 ctl ", tag}, 32'(ctl_word), 32'(e_ctl));
      chk({"R5/R10 nsp ", tag}, 32'(nsp_word), 32'(e_noise));
      for (int i = 0; i < 4; i++)
         chk({"R9 strobe count ", tag}, 32'(s_cnt[i]), 32'(e_cnt[i]));
      chk({"R9 strobe width ", tag}, 32'(s_wide), 32'd0);
      chk({"R9 strobe overlap ", tag}, 32'(s_multi), 32'd0);
   endtask

   task automatic model_write(input logic [23:0] w);
      case (w[1:0])
         2'b00: begin e_frac = w[13:2]; e_int = w[22:14]; e_nsp1 = w[23]; e_mod = e_stg; end
         2'b01: begin e_stg = w[13:2]; e_ref = w[17:14]; e_rsp = w[23:18]; end
         2'b10: e_ctl = w[23:2];
         default: e_noise = w[23:2];
      endcase
      e_cnt[w[1:0]]++;
   endtask

   task automatic ser_bit(input logic b);
      @(negedge clk) ser_dat = b;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic shift_bits(input logic [63:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) ser_bit(w[i]);
   endtask

   task automatic pulse_latch();
      repeat (4) @(negedge clk);
      ser_latch = 1'b1;
      repeat (4) @(negedge clk);
      ser_latch = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic write_word(input logic [23:0] w);
      shift_bits(64'(w), 24);
      pulse_latch();
      model_write(w);
   endtask

   function automatic logic [23:0] n_word(input logic s, input logic [8:0] iv, input logic [11:0] fv);
      return {s, iv, fv, 2'b00};
   endfunction

   function automatic logic [23:0] r_word(input logic [5:0] s, input logic [3:0] rv, input logic [11:0] mv);
      return {s, rv, mv, 2'b01};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      e_ref = '0; e_int = '0; e_frac = '0; e_nsp1 = '0; e_rsp = '0;
      e_ctl = '0; e_noise = '0; e_mod = 12'd2; e_stg = 12'd2;
      for (int i = 0; i < 4; i++) begin e_cnt[i] = 0; s_cnt[i] = 0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R8 reset");

      // R4 and R6: staging a modulus leaves the active one at its reset value
      write_word(r_word(6'h2a, 4'd5, 12'd100));
      check_all("R4 stage");
      chk("R6 mod before commit", 32'(mod_val), 32'd2);
      // R7: commit on the integer write
      write_word(n_word(1'b1, 9'h1a5, 12'habc));
      chk("R7 mod committed", 32'(mod_val), 32'd100);
      check_all("R3 first N");
      // R7: a second N write keeps the committed modulus
      write_word(n_word(1'b0, 9'h003, 12'h001));
      check_all("R7 repeat N");
      // R7: last of two staged values wins
      write_word(r_word(6'h01, 4'd9, 12'd7));
      write_word(r_word(6'h3f, 4'd15, 12'd9));
      check_all("R6 two stages");
      write_word(n_word(1'b1, 9'h100, 12'hfff));
      chk("R7 last staged wins", 32'(mod_val), 32'd9);
      // R5: control and noise/spur words
      write_word({22'h2d_5a5a, 2'b10});
      check_all("R5 ctl");
      write_word({22'h15_a5a5, 2'b11});
      check_all("R5 nsp");
      // R2 and R1: older bits beyond 24 are lost
      shift_bits({34'h0, 6'b101101, 24'h123458}, 30);
      pulse_latch();
      model_write(24'h123458);
      check_all("R2 extra bits");
      // R11: shifting without a latch changes nothing
      shift_bits(64'(24'hfedcb6), 24);
      repeat (10) @(negedge clk);
      check_all("R11 no latch");
      // R4/R7 sweep over every reference value
      for (int r = 0; r < 16; r++) begin
         write_word(r_word(6'(r * 3), 4'(r), 12'(r * 257 + 1)));
         check_all("R4 sweep ref");
         write_word(n_word(1'(r), 9'(r * 31), 12'(r * 200)));
         check_all("R7 sweep commit");
      end
      // R10: pseudo-random words to every destination code
      seed = 32'h1234_5678;
      for (int k = 0; k < 32; k++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         write_word({seed[23:2], 2'(k % 4)});
         check_all("R10 sweep");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule